// File: doc/BRIEF.md
# Register-Prefix ALU Execute Unit

This block is the execute stage for register-addressed instructions whose first byte names a source register and an operand size. It holds eight 32-bit general registers and four status flags (sign, zero, overflow, carry). The instruction arrives already split into fields: a 2-bit size code, the 3-bit source field from the prefix, the 8-bit sub-opcode and a 32-bit immediate word. The block executes it in the clock edge where `startValid` is high, and it pulses `done` in the following cycle.

The sub-opcode selects the operation. For most operations its low three bits are either the second register field or a small constant. The unit covers two-register and immediate arithmetic and logic, compares, register moves in both directions, increment and decrement by a small count, small-constant loads, complement, negate, byte-to-word extension and a set-on-condition operation driven by a 4-bit condition code. A combinational read port exposes any 32-bit register so that the surrounding pipeline can observe the register contents.

Top module: `prefix_alu_exec`

## Requirements
- R1: After reset all eight registers read zero, `flags` is 0, and `done` and `illegal` are low.
- R2: Register field codes select registers by size. At size 0 (8-bit), code c addresses register c>>1: bits 15:8 when c is even, bits 7:0 when c is odd. At size 1 (16-bit), code c addresses bits 15:0 of register c. At size 2 (32-bit), code c addresses all of register c. A write at 8 or 16 bits leaves the other bits of the register unchanged.
- R3: With d equal to sub-opcode bits 2:0 and r the source field, the sub-opcodes work as follows. 0x80+d: d←d+r. 0x90+d: d←d+r+C. 0xA0+d: d←d−r. 0xB0+d: d←d−r−C. 0xC0+d: d←d AND r. 0xD0+d: d←d XOR r. 0xE0+d: d←d OR r.
- R4: 0xF0+d sets the flags from d−r, and 0xD8+n sets the flags from r−n. Neither writes a register.
- R5: 0xC8..0xCF apply, in order, add, add-with-carry, subtract, subtract-with-borrow, AND, XOR, OR and compare to r and the immediate, which is cut to the operand size. Every form except compare writes r. 0x03 loads the sized immediate into r and leaves the flags unchanged.
- R6: 0x20+d and 0x88+d copy r into d. 0x28+d and 0x98+d copy d into r. The flags do not change.
- R7: 0x60+n adds n to r and 0x68+n subtracts n from r, for n from 1 to 7. These update S, Z and V and keep C. A count of 0 is illegal.
- R8: 0xA8+n loads the constant n (0..7) into r and leaves the flags unchanged.
- R9: 0x06 writes the bitwise complement of r into r and leaves the flags unchanged. 0x07 writes 0−r into r and sets the flags as a subtraction would.
- R10: At size 1 only, 0x12 zero-extends and 0x13 sign-extends the low byte of r into r, with the flags unchanged. At any other size both codes are illegal.
- R11: 0x70+cc writes 1 or 0 into r according to the condition code cc. The codes are 0 never, 1 S^V, 2 (S^V)|Z, 3 C|Z, 4 V, 5 S, 6 Z, 7 C. Codes 8 to 15 are the inverses of codes 0 to 7. The flags are unchanged.
- R12: `flags` is {S,Z,V,C}, computed at the operand size. S is the top bit of the result and Z means the result is zero. C is the carry out of an addition or the borrow of a subtraction. V is signed overflow. AND, XOR and OR clear both V and C.
- R13: `done` is high in the cycle after each cycle in which `startValid` is high, and low otherwise. Instructions may be issued back to back.
- R14: Size code 3, a sub-opcode outside the listed set, or any case marked illegal above raises `illegal` together with `done`, and changes no register and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Execute the presented instruction at this edge |
| opSize | input | 2 | Operand size: 0 = 8, 1 = 16, 2 = 32 bits, 3 = illegal |
| srcField | input | 3 | Source register field r from the prefix |
| subOp | input | 8 | Sub-opcode |
| immVal | input | 32 | Immediate operand, low-aligned |
| rdIdx | input | 3 | Register index for the read port |
| rdData | output | 32 | Full 32-bit content of register rdIdx |
| done | output | 1 | Completion pulse, one cycle after acceptance |
| illegal | output | 1 | Instruction was rejected; valid with done |
| flags | output | 4 | Status flags {S,Z,V,C} |

## Verification
The checker watches, on every cycle, the timing of the completion pulse and the following properties. A rejected instruction leaves the flags untouched. Size code 3 and extension at the wrong size are always rejected. Moves leave the flags alone. Idle cycles change neither the flags nor any register seen through the read port. Computed values can only be shown by the bench's scenarios. These include carry and borrow chaining through add-with-carry and subtract-with-borrow, overflow at each operand width, byte-lane and halfword merging into wider registers, carry retention across increment and decrement, and the truth table of the condition codes.

// File: rtl/prefix_alu_pkg.sv
package prefix_alu_pkg;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_XOR, ALU_OR,
    ALU_PASS, ALU_NOT, ALU_EXTZ, ALU_EXTS, ALU_SCC
  } alu_e;

  // Left operand selection
  typedef enum logic [1:0] { A_DST, A_SRC, A_ZERO } asel_e;

  // Right operand selection
  typedef enum logic [1:0] { B_SRC, B_DST, B_IMM, B_SMALL } bsel_e;

  // Strobes from control to datapath
  typedef struct packed {
    alu_e  aluOp;
    asel_e aSel;
    bsel_e bSel;
    logic  useCarry;   // add carry-in / subtract borrow-in
    logic  wrToDst;    // write field d (else field r)
    logic  wrReg;      // commit a register write
    logic  wrFlags;    // commit a flag update
    logic  keepCarry;  // hold C through the flag update
    logic  logicFlags; // clear V and C
    logic  bad;        // instruction rejected
  } strobe_t;

  localparam logic [1:0] SIZE_BYTE = 2'd0;
  localparam logic [1:0] SIZE_WORD = 2'd1;
  localparam logic [1:0] SIZE_LONG = 2'd2;
  localparam logic [1:0] SIZE_BAD  = 2'd3;

endpackage

// File: rtl/prefix_alu_ctrl.sv
module prefix_alu_ctrl
  import prefix_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [1:0]        opSize,
  input  logic [7:0]        subOp,
  output strobe_t           strb,
  output logic              done,
  output logic              illegal
);

  logic [4:0] opGroup;
  logic [2:0] lowField;
  strobe_t    dec;

  assign opGroup  = subOp[7:3];
  assign lowField = subOp[2:0];

  always_comb begin
    dec            = '0;
    dec.aluOp      = ALU_PASS;
    dec.aSel       = A_SRC;
    dec.bSel       = B_SRC;
    unique case (opGroup)
      5'b10000: begin // add reg
        dec.aluOp = ALU_ADD; dec.aSel = A_DST; dec.wrToDst = 1'b1;
        dec.wrReg = 1'b1; dec.wrFlags = 1'b1;
      end
      5'b10010: begin // add with carry reg
        dec.aluOp = ALU_ADD; dec.aSel = A_DST; dec.useCarry = 1'b1;
        dec.wrToDst = 1'b1; dec.wrReg = 1'b1; dec.wrFlags = 1'b1;
      end
      5'b10100: begin // subtract reg
        dec.aluOp = ALU_SUB; dec.aSel = A_DST; dec.wrToDst = 1'b1;
        dec.wrReg = 1'b1; dec.wrFlags = 1'b1;
      end
      5'b10110: begin // subtract with borrow reg
        dec.aluOp = ALU_SUB; dec.aSel = A_DST; dec.useCarry = 1'b1;
        dec.wrToDst = 1'b1; dec.wrReg = 1'b1; dec.wrFlags = 1'b1;
      end
      5'b11000, 5'b11010, 5'b11100: begin // and / xor / or reg
        dec.aluOp = (opGroup == 5'b11000) ? ALU_AND :
                    (opGroup == 5'b11010) ? ALU_XOR : ALU_OR;
        dec.aSel = A_DST; dec.wrToDst = 1'b1; dec.wrReg = 1'b1;
        dec.wrFlags = 1'b1; dec.logicFlags = 1'b1;
      end
      5'b11110: begin // compare reg
        dec.aluOp = ALU_SUB; dec.aSel = A_DST; dec.wrFlags = 1'b1;
      end
      5'b11001: begin // immediate arithmetic / logic
        dec.aSel = A_SRC; dec.bSel = B_IMM; dec.wrFlags = 1'b1;
        dec.wrReg = (lowField != 3'd7);
        unique case (lowField)
          3'd0: dec.aluOp = ALU_ADD;
          3'd1: begin dec.aluOp = ALU_ADD; dec.useCarry = 1'b1; end
          3'd2: dec.aluOp = ALU_SUB;
          3'd3: begin dec.aluOp = ALU_SUB; dec.useCarry = 1'b1; end
          3'd4: begin dec.aluOp = ALU_AND; dec.logicFlags = 1'b1; end
          3'd5: begin dec.aluOp = ALU_XOR; dec.logicFlags = 1'b1; end
          3'd6: begin dec.aluOp = ALU_OR;  dec.logicFlags = 1'b1; end
          default: dec.aluOp = ALU_SUB;
        endcase
      end
      5'b11011: begin // compare with small constant
        dec.aluOp = ALU_SUB; dec.aSel = A_SRC; dec.bSel = B_SMALL;
        dec.wrFlags = 1'b1;
      end
      5'b00100, 5'b10001: begin // move r into d
        dec.aluOp = ALU_PASS; dec.bSel = B_SRC; dec.wrToDst = 1'b1;
        dec.wrReg = 1'b1;
      end
      5'b00101, 5'b10011: begin // move d into r
        dec.aluOp = ALU_PASS; dec.bSel = B_DST; dec.wrReg = 1'b1;
      end
      5'b10101: begin // load small constant
        dec.aluOp = ALU_PASS; dec.bSel = B_SMALL; dec.wrReg = 1'b1;
      end
      5'b01100, 5'b01101: begin // increment / decrement by count
        dec.aluOp = (opGroup == 5'b01100) ? ALU_ADD : ALU_SUB;
        dec.aSel = A_SRC; dec.bSel = B_SMALL; dec.wrReg = 1'b1;
        dec.wrFlags = 1'b1; dec.keepCarry = 1'b1;
        dec.bad = (lowField == 3'd0);
      end
      5'b01110, 5'b01111: begin // set on condition
        dec.aluOp = ALU_SCC; dec.wrReg = 1'b1;
      end
      5'b00000: begin
        unique case (lowField)
          3'd3: begin dec.aluOp = ALU_PASS; dec.bSel = B_IMM; dec.wrReg = 1'b1; end
          3'd6: begin dec.aluOp = ALU_NOT; dec.bSel = B_SRC; dec.wrReg = 1'b1; end
          3'd7: begin
            dec.aluOp = ALU_SUB; dec.aSel = A_ZERO; dec.bSel = B_SRC;
            dec.wrReg = 1'b1; dec.wrFlags = 1'b1;
          end
          default: dec.bad = 1'b1;
        endcase
      end
      5'b00010: begin
        if ((lowField == 3'd2 || lowField == 3'd3) && opSize == SIZE_WORD) begin
          dec.aluOp = (lowField == 3'd2) ? ALU_EXTZ : ALU_EXTS;
          dec.bSel  = B_SRC;
          dec.wrReg = 1'b1;
        end else begin
          dec.bad = 1'b1;
        end
      end
      default: dec.bad = 1'b1;
    endcase
    if (opSize == SIZE_BAD) dec.bad = 1'b1;
  end

  always_comb begin
    strb         = dec;
    strb.wrReg   = dec.wrReg   & startValid & ~dec.bad;
    strb.wrFlags = dec.wrFlags & startValid & ~dec.bad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done    <= startValid;
      illegal <= startValid & dec.bad;
    end
  end

endmodule

// File: rtl/prefix_alu_dpath.sv
module prefix_alu_dpath
  import prefix_alu_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     strb,
  input  logic [1:0]                  opSize,
  input  logic [$clog2(NUM_REGS)-1:0] srcField,
  input  logic [$clog2(NUM_REGS)-1:0] lowField,
  input  logic [3:0]                  condCode,
  input  logic [DATA_W-1:0]           immVal,
  input  logic [$clog2(NUM_REGS)-1:0] rdIdx,
  output logic [DATA_W-1:0]           rdData,
  output logic [3:0]                  flags
);

  localparam int IDX_W  = $clog2(NUM_REGS);
  localparam int BYTE_W = DATA_W / 4;
  localparam int HALF_W = DATA_W / 2;

  logic [NUM_REGS-1:0][DATA_W-1:0] regFile;
  logic flagS, flagZ, flagV, flagC;

  function automatic logic [DATA_W-1:0] pickField(
      input logic [NUM_REGS-1:0][DATA_W-1:0] rf,
      input logic [1:0] sz,
      input logic [IDX_W-1:0] idx);
    logic [DATA_W-1:0] pairReg;
    logic [DATA_W-1:0] val;
    pairReg = rf[{1'b0, idx[IDX_W-1:1]}];
    val     = '0;
    case (sz)
      SIZE_BYTE: val[BYTE_W-1:0] = idx[0] ? pairReg[BYTE_W-1:0]
                                          : pairReg[2*BYTE_W-1:BYTE_W];
      SIZE_WORD: val[HALF_W-1:0] = rf[idx][HALF_W-1:0];
      default:   val = rf[idx];
    endcase
    return val;
  endfunction

  function automatic logic topBit(input logic [DATA_W-1:0] v, input logic [1:0] sz);
    case (sz)
      SIZE_BYTE: return v[BYTE_W-1];
      SIZE_WORD: return v[HALF_W-1];
      default:   return v[DATA_W-1];
    endcase
  endfunction

  logic [DATA_W-1:0] sizeMask;
  logic [DATA_W-1:0] srcVal, dstVal, opA, opB, rawRes, resVal;
  logic [DATA_W:0]   sumExt, diffExt;
  logic              carryIn, condBase, condHit;
  logic              aTop, bTop, rTop, addOv, subOv, carryOut;
  logic              nextS, nextZ, nextV, nextC;
  logic [IDX_W-1:0]  wrIdx;

  always_comb begin
    case (opSize)
      SIZE_BYTE: sizeMask = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
      SIZE_WORD: sizeMask = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
      default:   sizeMask = {DATA_W{1'b1}};
    endcase
  end

  assign srcVal = pickField(regFile, opSize, srcField);
  assign dstVal = pickField(regFile, opSize, lowField);

  always_comb begin
    case (strb.aSel)
      A_DST:   opA = dstVal;
      A_SRC:   opA = srcVal;
      default: opA = '0;
    endcase
    case (strb.bSel)
      B_SRC:   opB = srcVal;
      B_DST:   opB = dstVal;
      B_IMM:   opB = immVal & sizeMask;
      default: opB = {{(DATA_W-IDX_W){1'b0}}, lowField};
    endcase
  end

  // Condition evaluation; the top bit of the code inverts the test
  always_comb begin
    case (condCode[2:0])
      3'd0:    condBase = 1'b0;
      3'd1:    condBase = flagS ^ flagV;
      3'd2:    condBase = (flagS ^ flagV) | flagZ;
      3'd3:    condBase = flagC | flagZ;
      3'd4:    condBase = flagV;
      3'd5:    condBase = flagS;
      3'd6:    condBase = flagZ;
      default: condBase = flagC;
    endcase
    condHit = condBase ^ condCode[3];
  end

  assign carryIn = strb.useCarry & flagC;
  assign sumExt  = {1'b0, opA} + {1'b0, opB} + {{DATA_W{1'b0}}, carryIn};
  assign diffExt = {1'b0, opA} - {1'b0, opB} - {{DATA_W{1'b0}}, carryIn};

  always_comb begin
    case (strb.aluOp)
      ALU_ADD:  rawRes = sumExt[DATA_W-1:0];
      ALU_SUB:  rawRes = diffExt[DATA_W-1:0];
      ALU_AND:  rawRes = opA & opB;
      ALU_XOR:  rawRes = opA ^ opB;
      ALU_OR:   rawRes = opA | opB;
      ALU_NOT:  rawRes = ~opB;
      ALU_EXTZ: rawRes = {{(DATA_W-BYTE_W){1'b0}}, opB[BYTE_W-1:0]};
      ALU_EXTS: rawRes = {{(DATA_W-BYTE_W){opB[BYTE_W-1]}}, opB[BYTE_W-1:0]};
      ALU_SCC:  rawRes = {{(DATA_W-1){1'b0}}, condHit};
      default:  rawRes = opB;
    endcase
    resVal = rawRes & sizeMask;
  end

  always_comb begin
    case (opSize)
      SIZE_BYTE: carryOut = (strb.aluOp == ALU_SUB) ? diffExt[BYTE_W] : sumExt[BYTE_W];
      SIZE_WORD: carryOut = (strb.aluOp == ALU_SUB) ? diffExt[HALF_W] : sumExt[HALF_W];
      default:   carryOut = (strb.aluOp == ALU_SUB) ? diffExt[DATA_W] : sumExt[DATA_W];
    endcase
    aTop  = topBit(opA, opSize);
    bTop  = topBit(opB, opSize);
    rTop  = topBit(resVal, opSize);
    addOv = (aTop == bTop) && (rTop != aTop);
    subOv = (aTop != bTop) && (rTop != aTop);
    nextS = rTop;
    nextZ = (resVal == '0);
    nextV = strb.logicFlags ? 1'b0 : ((strb.aluOp == ALU_SUB) ? subOv : addOv);
    nextC = strb.keepCarry ? flagC : (strb.logicFlags ? 1'b0 : carryOut);
  end

  assign wrIdx = strb.wrToDst ? lowField : srcField;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regFile <= '0;
      flagS   <= 1'b0;
      flagZ   <= 1'b0;
      flagV   <= 1'b0;
      flagC   <= 1'b0;
    end else begin
      if (strb.wrReg) begin
        case (opSize)
          SIZE_BYTE: begin
            if (wrIdx[0])
              regFile[{1'b0, wrIdx[IDX_W-1:1]}][BYTE_W-1:0] <= resVal[BYTE_W-1:0];
            else
              regFile[{1'b0, wrIdx[IDX_W-1:1]}][2*BYTE_W-1:BYTE_W] <= resVal[BYTE_W-1:0];
          end
          SIZE_WORD: regFile[wrIdx][HALF_W-1:0] <= resVal[HALF_W-1:0];
          default:   regFile[wrIdx] <= resVal;
        endcase
      end
      if (strb.wrFlags) begin
        flagS <= nextS;
        flagZ <= nextZ;
        flagV <= nextV;
        flagC <= nextC;
      end
    end
  end

  assign rdData = regFile[rdIdx];
  assign flags  = {flagS, flagZ, flagV, flagC};

endmodule

// File: rtl/prefix_alu_exec.sv
module prefix_alu_exec
  import prefix_alu_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        startValid,
  input  logic [1:0]                  opSize,
  input  logic [$clog2(NUM_REGS)-1:0] srcField,
  input  logic [7:0]                  subOp,
  input  logic [DATA_W-1:0]           immVal,
  input  logic [$clog2(NUM_REGS)-1:0] rdIdx,
  output logic [DATA_W-1:0]           rdData,
  output logic                        done,
  output logic                        illegal,
  output logic [3:0]                  flags
);

  localparam int IDX_W = $clog2(NUM_REGS);

  strobe_t strb;

  prefix_alu_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .opSize     (opSize),
    .subOp      (subOp),
    .strb       (strb),
    .done       (done),
    .illegal    (illegal)
  );

  prefix_alu_dpath #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .opSize   (opSize),
    .srcField (srcField),
    .lowField (subOp[IDX_W-1:0]),
    .condCode (subOp[3:0]),
    .immVal   (immVal),
    .rdIdx    (rdIdx),
    .rdData   (rdData),
    .flags    (flags)
  );

endmodule

// File: rtl/prefix_alu_checker.sv
module prefix_alu_checker #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              startValid,
  input logic [1:0]        opSize,
  input logic [7:0]        subOp,
  input logic [IDX_W-1:0]  rdIdx,
  input logic [DATA_W-1:0] rdData,
  input logic              done,
  input logic              illegal,
  input logic [3:0]        flags
);

  p_done_after_start_r13: assert property (@(posedge clk) disable iff (!rstN)
    startValid |=> done);

  p_no_done_when_idle_r13: assert property (@(posedge clk) disable iff (!rstN)
    !startValid |=> !done);

  p_illegal_with_done_r14: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> done);

  p_bad_size_rejected_r14: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && opSize == 2'd3) |=> illegal);

  p_reject_keeps_flags_r14: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && opSize == 2'd3) |=> $stable(flags));

  p_extend_size_r10: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && opSize != 2'd1 && (subOp == 8'h12 || subOp == 8'h13)) |=> illegal);

  p_move_keeps_flags_r6: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && (subOp[7:3] == 5'b00100 || subOp[7:3] == 5'b10001)) |=> $stable(flags));

  p_idle_flags_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !startValid |=> $stable(flags));

  p_idle_regs_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!startValid ##1 $stable(rdIdx)) |-> $stable(rdData));

endmodule

bind prefix_alu_exec prefix_alu_checker #(
  .DATA_W (DATA_W),
  .IDX_W  ($clog2(NUM_REGS))
) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .startValid (startValid),
  .opSize     (opSize),
  .subOp      (subOp),
  .rdIdx      (rdIdx),
  .rdData     (rdData),
  .done       (done),
  .illegal    (illegal),
  .flags      (flags)
);

// File: tb/prefix_alu_exec_bench.sv
module prefix_alu_exec_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic [1:0]  opSize = 2'd0;
  logic [2:0]  srcField = 3'd0;
  logic [7:0]  subOp = 8'h00;
  logic [31:0] immVal = 32'h0;
  logic [2:0]  rdIdx = 3'd0;
  logic [31:0] rdData;
  logic        done, illegal;
  logic [3:0]  flags;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  logic [2:0]  qIdx[$];
  logic [31:0] qData[$];
  logic [3:0]  qFlg[$];
  logic        qIll[$];
  string       qTag[$];

  always #10 clk = ~clk;

  prefix_alu_exec u_prefix_alu_exec (
    .clk(clk), .rstN(rstN), .startValid(startValid), .opSize(opSize),
    .srcField(srcField), .subOp(subOp), .immVal(immVal), .rdIdx(rdIdx),
    .rdData(rdData), .done(done), .illegal(illegal), .flags(flags)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Driver: present one instruction and queue its expected outcome
  task automatic issue(input logic [1:0] sz, input logic [2:0] src, input logic [7:0] op,
                       input logic [31:0] imm, input logic [2:0] chkIdx,
                       input logic [31:0] expData, input logic [3:0] expFlg,
                       input logic expIll, input string tag);
    @(negedge clk);
    startValid = 1'b1;
    opSize = sz; srcField = src; subOp = op; immVal = imm;
    qIdx.push_back(chkIdx); qData.push_back(expData);
    qFlg.push_back(expFlg); qIll.push_back(expIll); qTag.push_back(tag);
  endtask

  // Monitor: compare each completion against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        if (qIdx.size() == 0) begin
          check("R13 unexpected done", 32'd1, 32'd0);
        end else begin
          logic [2:0] ci;
          string tg;
          logic [31:0] ed;
          logic [3:0] ef;
          logic ei;
          ci = qIdx.pop_front(); ed = qData.pop_front(); ef = qFlg.pop_front();
          ei = qIll.pop_front(); tg = qTag.pop_front();
          rdIdx = ci;
          #1;
          check({tg, " reg"}, rdData, ed);
          check({tg, " flags"}, {28'd0, flags}, {28'd0, ef});
          check({tg, " illegal"}, {31'd0, illegal}, {31'd0, ei});
        end
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired got=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 8; i++) begin
      rdIdx = 3'(i);
      #1;
      check("R1 reset reg", rdData, 32'h0);
    end
    check("R1 reset flags", {28'd0, flags}, 32'd0);
    check("R1 reset done", {31'd0, done}, 32'd0);
    check("R1 reset illegal", {31'd0, illegal}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    issue(2, 0, 8'h03, 32'h12345678, 0, 32'h12345678, 4'b0000, 0, "R5 load imm long");
    issue(2, 1, 8'h03, 32'h000000F0, 1, 32'h000000F0, 4'b0000, 0, "R5 load imm long");
    issue(0, 3, 8'h81, 0, 0, 32'h12345668, 4'b0001, 0, "R3 R2 add byte lane low");
    issue(1, 1, 8'h90, 0, 0, 32'h12345759, 4'b0000, 0, "R3 adc word");
    issue(2, 2, 8'h03, 32'h80000000, 2, 32'h80000000, 4'b0000, 0, "R5 load imm");
    issue(2, 1, 8'hA2, 0, 2, 32'h7FFFFF10, 4'b0010, 0, "R3 R12 sub overflow");
    issue(2, 1, 8'hCF, 32'h000000F0, 1, 32'h000000F0, 4'b0100, 0, "R5 R4 compare imm");
    issue(1, 3, 8'hD9, 0, 3, 32'h00000000, 4'b1001, 0, "R4 compare small borrow");
    issue(0, 3, 8'hB1, 0, 0, 32'h12345768, 4'b0001, 0, "R3 sbc byte");
    issue(1, 1, 8'hC0, 0, 0, 32'h12340060, 4'b0000, 0, "R3 R12 and word");
    issue(2, 0, 8'hCD, 32'h12340060, 0, 32'h00000000, 4'b0100, 0, "R5 xor imm zero");
    issue(0, 3, 8'hE0, 0, 0, 32'h0000F000, 4'b1000, 0, "R3 R2 or byte high lane");
    issue(2, 2, 8'h25, 0, 5, 32'h7FFFFF10, 4'b1000, 0, "R6 move to d");
    issue(1, 4, 8'h9D, 0, 4, 32'h0000FF10, 4'b1000, 0, "R6 move to r alt");
    issue(0, 0, 8'h8F, 0, 3, 32'h000000F0, 4'b1000, 0, "R6 R2 move byte alt");
    issue(2, 6, 8'h29, 0, 6, 32'h000000F0, 4'b1000, 0, "R6 move to r");
    issue(1, 7, 8'h03, 32'hABCD7FFF, 7, 32'h00007FFF, 4'b1000, 0, "R5 load imm sized");
    issue(1, 7, 8'h61, 0, 7, 32'h00008000, 4'b1010, 0, "R7 inc overflow");
    issue(0, 2, 8'hD9, 0, 1, 32'h000000F0, 4'b1001, 0, "R4 compare small byte");
    issue(0, 2, 8'h6A, 0, 1, 32'h0000FEF0, 4'b1001, 0, "R7 dec keeps carry");
    issue(2, 2, 8'h60, 0, 2, 32'h7FFFFF10, 4'b1001, 1, "R7 R14 zero count");
    issue(2, 4, 8'hA8, 0, 4, 32'h00000000, 4'b1001, 0, "R8 load small zero");
    issue(1, 4, 8'h07, 0, 4, 32'h00000000, 4'b0100, 0, "R9 negate zero");
    issue(2, 4, 8'hAD, 0, 4, 32'h00000005, 4'b0100, 0, "R8 load small five");
    issue(2, 4, 8'h07, 0, 4, 32'hFFFFFFFB, 4'b1001, 0, "R9 negate long");
    issue(2, 4, 8'h06, 0, 4, 32'h00000004, 4'b1001, 0, "R9 complement");
    issue(1, 1, 8'h13, 0, 1, 32'h0000FFF0, 4'b1001, 0, "R10 sign extend");
    issue(1, 1, 8'h12, 0, 1, 32'h000000F0, 4'b1001, 0, "R10 zero extend");
    issue(2, 1, 8'h12, 0, 1, 32'h000000F0, 4'b1001, 1, "R10 R14 extend wrong size");
    issue(2, 6, 8'h77, 0, 6, 32'h00000001, 4'b1001, 0, "R11 cond carry");
    issue(0, 0, 8'h7E, 0, 0, 32'h00000100, 4'b1001, 0, "R11 cond not zero");
    issue(1, 6, 8'h70, 0, 6, 32'h00000000, 4'b1001, 0, "R11 cond never");
    issue(2, 6, 8'h72, 0, 6, 32'h00000001, 4'b1001, 0, "R11 cond less or equal");
    issue(2, 6, 8'h7A, 0, 6, 32'h00000000, 4'b1001, 0, "R11 cond greater");
    issue(2, 6, 8'h73, 0, 6, 32'h00000001, 4'b1001, 0, "R11 cond unsigned le");
    issue(2, 0, 8'h00, 0, 0, 32'h00000100, 4'b1001, 1, "R14 unknown subop");
    issue(3, 0, 8'h80, 0, 0, 32'h00000100, 4'b1001, 1, "R14 bad size");
    issue(0, 0, 8'hC8, 32'h0000007F, 0, 32'h00008000, 4'b1010, 0, "R5 R12 add imm overflow");

    @(negedge clk);
    startValid = 1'b0;
    repeat (3) @(negedge clk);
    check("R13 done low when idle", {31'd0, done}, 32'd0);
    check("R13 all items completed", qIdx.size(), 32'd0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule